// File: doc/BRIEF.md
# Eight-Line Vectored Interrupt Controller

This block gathers eight interrupt request lines, ranks them by a fixed priority, and raises one interrupt line to a processor. When the processor acknowledges, the block hands back an 8-bit vector. The vector is a programmed base with the winning line number in its low three bits. An in-service register records which levels are being handled. Until a level is retired, that level and every level below it are held off.

A host programs the block through a two-address byte bus. Address 0 is the command port and address 1 is the data port. Writes and reads are single-cycle strobes. A start byte on the command port opens an ordered initialisation: the data port then takes a vector base word, a cascade word and, optionally, a mode word. After that, the data port reads and writes the mask register. Command-port bytes choose whether command-port reads return the request register or the in-service register, and retire a level by a coded end-of-interrupt. Alternatively, the mode word turns on automatic retirement.

The vector leaves through a valid/ready pair. A captured vector stays on `vec_data`, with `vec_valid` high, until the processor side raises `vec_ready`. No new acknowledge is accepted while a vector waits.

Top module: `pvic_top`

## Requirements
- R1: After reset, `cpu_int` and `vec_valid` are low, the mask and in-service registers are zero, the vector base is zero, and command-port reads return the request register.
- R2: A command write with bit 4 set (0x11 or 0x10) starts initialisation. The next data writes are taken in order as base word, then cascade word, then mode word. The mode word is only expected when bit 0 of the start byte is 1. None of these words reaches the mask. The start byte clears the mask and the in-service register, turns automatic retirement off, and sets readback to the request register.
- R3: An accepted acknowledge yields the vector {base word bits 7..3, line number}. The low three bits of the base word are ignored.
- R4: A rising edge on a line sets its request bit one clock later. A falling edge clears a request bit that has not yet been acknowledged.
- R5: A data-port write after initialisation loads the mask, and a data-port read returns it. Mask bit n blocks line n. Writing 0xFF blocks every line, and writing back an earlier value re-enables exactly those lines.
- R6: Priority is fixed, with line 0 highest. `cpu_int` is high exactly when an unmasked request exists at a lower line number than every set in-service bit.
- R7: When `ack_req` is high while no vector is pending and `cpu_int` is high, the winning request bit is cleared, its in-service bit is set, and `vec_valid` rises on the next clock. An `ack_req` while `vec_valid` is high is ignored.
- R8: `vec_valid` and `vec_data` hold steady until a clock in which `vec_valid` and `vec_ready` are both high. After that clock, `vec_valid` is low.
- R9: An acknowledge accepted while `cpu_int` is low returns the vector with line number 7 and changes no in-service bit.
- R10: Command byte 0x0B selects the in-service register for command-port reads, and 0x0A selects the request register. Read data appears on `bus_rdata` one clock after the read strobe and holds there.
- R11: Command byte 0x60+L (L from 0 to 7) clears in-service bit L and no other bit.
- R12: When mode word bit 1 is set, the in-service bit of an acknowledged level stays set while its vector waits and is cleared on the clock that completes the vector transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 1 | 0 selects the command port, 1 the data port |
| bus_wr | input | 1 | Write strobe, one clock per byte |
| bus_rd | input | 1 | Read strobe, one clock per byte |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| irq_line | input | NLINES | Interrupt request lines, synchronous to clk |
| cpu_int | output | 1 | Interrupt request to the processor |
| ack_req | input | 1 | Acknowledge request from the processor |
| vec_valid | output | 1 | A vector is waiting |
| vec_ready | input | 1 | The processor side takes the vector |
| vec_data | output | DW | Vector number |

## Verification
The bench builds the block with its defaults: eight lines and an 8-bit bus. With these defaults every level from 0 to 7 can be driven, the spurious vector lands on line 7, and the base word keeps five significant bits, so the discarded low bits can be seen in a returned vector. Nested levels, a masked burst, an acknowledge while a vector waits, a request that vanishes before its acknowledge, and a second initialisation over live state are each driven from the ports.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  typedef enum logic [1:0] {HS_RUN, HS_BASE, HS_CASC, HS_MODE} hs_state_t;

  localparam int START_BIT     = 4;
  localparam int NEED_MODE_BIT = 0;
  localparam int SEL_CMD_BIT   = 3;
  localparam int SEL_VALID_BIT = 1;
  localparam int SEL_ISR_BIT   = 0;
  localparam int AUTO_RET_BIT  = 1;
  localparam logic [2:0] SEOI_CODE = 3'b011;
endpackage

// File: rtl/pvic_prio.sv
module pvic_prio #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/pvic_host.sv
module pvic_host
  import pvic_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int DW     = 8,
  localparam int LW    = $clog2(NLINES),
  localparam int BW    = DW - LW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NLINES-1:0] irr,
  input  logic [NLINES-1:0] isr,
  output logic [NLINES-1:0] imr,
  output logic [BW-1:0]     base,
  output logic              auto_ret,
  output logic              init_clr,
  output logic              eoi_stb,
  output logic [LW-1:0]     eoi_lvl
);
  hs_state_t st_q;
  logic      need_mode_q;
  logic      sel_isr_q;
  logic      cmd_wr, dat_wr;

  assign cmd_wr   = bus_wr && !bus_addr;
  assign dat_wr   = bus_wr && bus_addr;
  assign init_clr = cmd_wr && bus_wdata[START_BIT];
  assign eoi_stb  = cmd_wr && !bus_wdata[START_BIT] && !bus_wdata[SEL_CMD_BIT]
                    && (bus_wdata[DW-1 -: 3] == SEOI_CODE);
  assign eoi_lvl  = bus_wdata[LW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= HS_RUN;
      need_mode_q <= 1'b0;
      sel_isr_q   <= 1'b0;
      imr         <= '0;
      base        <= '0;
      auto_ret    <= 1'b0;
      bus_rdata   <= '0;
    end else begin
      if (bus_rd) begin
        if (bus_addr)       bus_rdata <= DW'(imr);
        else if (sel_isr_q) bus_rdata <= DW'(isr);
        else                bus_rdata <= DW'(irr);
      end
      if (init_clr) begin
        st_q        <= HS_BASE;
        need_mode_q <= bus_wdata[NEED_MODE_BIT];
        sel_isr_q   <= 1'b0;
        imr         <= '0;
        auto_ret    <= 1'b0;
      end else if (cmd_wr && bus_wdata[SEL_CMD_BIT]) begin
        if (bus_wdata[SEL_VALID_BIT]) sel_isr_q <= bus_wdata[SEL_ISR_BIT];
      end else if (dat_wr) begin
        unique case (st_q)
          HS_BASE: begin
            base <= bus_wdata[DW-1:LW];
            st_q <= HS_CASC;
          end
          HS_CASC: st_q <= need_mode_q ? HS_MODE : HS_RUN;
          HS_MODE: begin
            auto_ret <= bus_wdata[AUTO_RET_BIT];
            st_q     <= HS_RUN;
          end
          default: imr <= bus_wdata[NLINES-1:0];
        endcase
      end
    end
  end
endmodule

// File: rtl/pvic_core.sv
module pvic_core #(
  parameter int NLINES = 8,
  parameter int DW     = 8,
  localparam int LW    = $clog2(NLINES),
  localparam int BW    = DW - LW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_line,
  input  logic [NLINES-1:0] imr,
  input  logic [BW-1:0]     base,
  input  logic              auto_ret,
  input  logic              init_clr,
  input  logic              eoi_stb,
  input  logic [LW-1:0]     eoi_lvl,
  input  logic              ack_req,
  input  logic              vec_ready,
  output logic [NLINES-1:0] irr,
  output logic [NLINES-1:0] isr,
  output logic              cpu_int,
  output logic              vec_valid,
  output logic [DW-1:0]     vec_data
);
  logic [NLINES-1:0] line_q, rise, fall, win_oh, eoi_oh, aret_oh;
  logic              pend_any, svc_any, take, real_ack, spur_q, xfer;
  logic [LW-1:0]     pend_idx, svc_idx;

  pvic_prio #(.N(NLINES)) u_pend (.req(irr & ~imr), .any(pend_any), .idx(pend_idx));
  pvic_prio #(.N(NLINES)) u_svc  (.req(isr),        .any(svc_any),  .idx(svc_idx));

  assign cpu_int  = pend_any && (!svc_any || (pend_idx < svc_idx));
  assign rise     = irq_line & ~line_q;
  assign fall     = ~irq_line & line_q;
  assign take     = ack_req && !vec_valid;
  assign real_ack = take && cpu_int;
  assign xfer     = vec_valid && vec_ready;
  assign win_oh   = real_ack ? (NLINES'(1) << pend_idx) : '0;
  assign eoi_oh   = eoi_stb ? (NLINES'(1) << eoi_lvl) : '0;
  assign aret_oh  = (xfer && auto_ret && !spur_q) ? (NLINES'(1) << vec_data[LW-1:0]) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q    <= '0;
      irr       <= '0;
      isr       <= '0;
      vec_valid <= 1'b0;
      vec_data  <= '0;
      spur_q    <= 1'b0;
    end else begin
      line_q <= irq_line;
      irr    <= (irr & ~fall & ~win_oh) | rise;
      if (init_clr) isr <= '0;
      else          isr <= (isr & ~eoi_oh & ~aret_oh) | win_oh;
      if (take) begin
        vec_valid <= 1'b1;
        spur_q    <= !real_ack;
        vec_data  <= {base, real_ack ? pend_idx : LW'(NLINES - 1)};
      end else if (xfer) begin
        vec_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pvic_top.sv
module pvic_top #(
  parameter int NLINES = 8,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NLINES-1:0] irq_line,
  output logic              cpu_int,
  input  logic              ack_req,
  output logic              vec_valid,
  input  logic              vec_ready,
  output logic [DW-1:0]     vec_data
);
  localparam int LW = $clog2(NLINES);
  localparam int BW = DW - LW;

  logic [NLINES-1:0] irr_w, isr_w, imr_w;
  logic [BW-1:0]     base_w;
  logic              aret_w, init_w, eoi_w;
  logic [LW-1:0]     eoi_lvl_w;

  pvic_host #(.NLINES(NLINES), .DW(DW)) u_host (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irr(irr_w), .isr(isr_w),
    .imr(imr_w), .base(base_w), .auto_ret(aret_w), .init_clr(init_w),
    .eoi_stb(eoi_w), .eoi_lvl(eoi_lvl_w)
  );

  pvic_core #(.NLINES(NLINES), .DW(DW)) u_core (
    .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .imr(imr_w), .base(base_w),
    .auto_ret(aret_w), .init_clr(init_w), .eoi_stb(eoi_w), .eoi_lvl(eoi_lvl_w),
    .ack_req(ack_req), .vec_ready(vec_ready), .irr(irr_w), .isr(isr_w),
    .cpu_int(cpu_int), .vec_valid(vec_valid), .vec_data(vec_data)
  );
endmodule

// File: rtl/pvic_chk.sv
module pvic_chk #(
  parameter int NLINES = 8,
  parameter int DW     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_addr,
  input logic              bus_wr,
  input logic [DW-1:0]     bus_wdata,
  input logic              ack_req,
  input logic              cpu_int,
  input logic              vec_valid,
  input logic              vec_ready,
  input logic [DW-1:0]     vec_data,
  input logic [NLINES-1:0] irr,
  input logic [NLINES-1:0] isr,
  input logic [NLINES-1:0] imr
);
  localparam int LW = $clog2(NLINES);
  logic start_wr, seoi_wr;
  assign start_wr = bus_wr && !bus_addr && bus_wdata[4];
  assign seoi_wr  = bus_wr && !bus_addr && (bus_wdata[7:3] == 5'b01100);

  assert_vec_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_data)));

  assert_int_unmasked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_int |-> ((irr & ~imr) != '0));

  assert_spurious_vec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !vec_valid && !cpu_int) |=> (vec_valid && (vec_data[LW-1:0] == LW'(NLINES - 1))));

  assert_ack_sets_isr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !vec_valid && cpu_int && !start_wr) |=> (vec_valid && isr[vec_data[LW-1:0]]));

  assert_eoi_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (seoi_wr && !ack_req) |=> !isr[$past(bus_wdata[LW-1:0])]);

  assert_init_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> ((isr == '0) && (imr == '0)));
endmodule

bind pvic_top pvic_chk #(.NLINES(NLINES), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .ack_req(ack_req), .cpu_int(cpu_int), .vec_valid(vec_valid), .vec_ready(vec_ready),
  .vec_data(vec_data), .irr(irr_w), .isr(isr_w), .imr(imr_w)
);

// File: tb/sim_pvic_top.sv
module sim_pvic_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] irq_line = '0;
  logic       cpu_int, ack_req = 1'b0, vec_valid, vec_ready = 1'b0;
  logic [7:0] vec_data;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pvic_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_line(irq_line), .cpu_int(cpu_int),
    .ack_req(ack_req), .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_data(vec_data)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic line(input int n, input logic v);
    @(negedge clk); irq_line[n] = v;
    @(negedge clk);
  endtask

  task automatic ack(input bit take_it, output logic [7:0] v);
    @(negedge clk); ack_req = 1'b1;
    @(negedge clk); ack_req = 1'b0; v = vec_data;
    chk("R7 vec_valid after ack", 8'(vec_valid), 8'h01);
    if (take_it) take();
  endtask

  task automatic take();
    @(negedge clk); vec_ready = 1'b1;
    @(negedge clk); vec_ready = 1'b0;
    chk("R8 vec_valid low after transfer", 8'(vec_valid), 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 cpu_int", 8'(cpu_int), 8'h00);
    chk("R1 vec_valid", 8'(vec_valid), 8'h00);
    rd(1'b1, d); chk("R1 mask", d, 8'h00);
    rd(1'b0, d); chk("R1 readback is request reg", d, 8'h00);
  endtask

  task automatic t_init_short();
    logic [7:0] d;
    wr(1'b0, 8'h10); wr(1'b1, 8'h80); wr(1'b1, 8'h04);
    wr(1'b1, 8'h55);
    rd(1'b1, d); chk("R2 no mode word, next write is mask", d, 8'h55);
  endtask

  task automatic t_init_full();
    logic [7:0] d;
    wr(1'b0, 8'h11);
    rd(1'b1, d); chk("R2 start clears mask", d, 8'h00);
    wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    rd(1'b1, d); chk("R2 init words stay out of mask", d, 8'h00);
  endtask

  task automatic t_basic();
    logic [7:0] d, v;
    line(3, 1'b1);
    chk("R4 rising edge raises cpu_int", 8'(cpu_int), 8'h01);
    rd(1'b0, d); chk("R10 request readback", d, 8'h08);
    ack(1'b1, v); chk("R3 vector base plus line", v, 8'h23);
    chk("R7 cpu_int drops after ack", 8'(cpu_int), 8'h00);
    wr(1'b0, 8'h0B); rd(1'b0, d); chk("R10 in-service readback", d, 8'h08);
    wr(1'b0, 8'h0A); rd(1'b0, d); chk("R7 request bit cleared", d, 8'h00);
    wr(1'b0, 8'h63); wr(1'b0, 8'h0B);
    rd(1'b0, d); chk("R11 specific retire level 3", d, 8'h00);
    line(3, 1'b0);
  endtask

  task automatic t_prio();
    logic [7:0] d, v;
    line(3, 1'b1); ack(1'b1, v); chk("R3 vector line 3", v, 8'h23);
    line(5, 1'b1); chk("R6 lower level held off", 8'(cpu_int), 8'h00);
    line(1, 1'b1); chk("R6 higher level preempts", 8'(cpu_int), 8'h01);
    ack(1'b1, v); chk("R6 nested vector", v, 8'h21);
    rd(1'b0, d); chk("R7 nested in-service", d, 8'h0A);
    wr(1'b0, 8'h61); rd(1'b0, d); chk("R11 only level 1 cleared", d, 8'h08);
    chk("R6 level 5 still held off", 8'(cpu_int), 8'h00);
    wr(1'b0, 8'h63); chk("R6 level 5 released", 8'(cpu_int), 8'h01);
    ack(1'b1, v); chk("R6 vector line 5", v, 8'h25);
    wr(1'b0, 8'h65); rd(1'b0, d); chk("R11 all retired", d, 8'h00);
    line(1, 1'b0); line(3, 1'b0); line(5, 1'b0);
  endtask

  task automatic t_backpressure();
    logic [7:0] d, v;
    @(negedge clk); irq_line[0] = 1'b1; irq_line[2] = 1'b1;
    @(negedge clk);
    ack(1'b0, v); chk("R3 vector line 0", v, 8'h20);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 valid held", 8'(vec_valid), 8'h01);
      chk("R8 data held", vec_data, 8'h20);
    end
    @(negedge clk); ack_req = 1'b1;
    @(negedge clk); ack_req = 1'b0;
    chk("R7 ack while pending ignored", vec_data, 8'h20);
    rd(1'b0, d); chk("R7 in-service unchanged by ignored ack", d, 8'h01);
    take();
    wr(1'b0, 8'h60); chk("R6 line 2 released", 8'(cpu_int), 8'h01);
    ack(1'b1, v); chk("R3 vector line 2", v, 8'h22);
    wr(1'b0, 8'h62);
    @(negedge clk); irq_line[0] = 1'b0; irq_line[2] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_mask();
    logic [7:0] d, v;
    wr(1'b1, 8'hFF);
    line(2, 1'b1); chk("R5 all masked", 8'(cpu_int), 8'h00);
    rd(1'b1, d); chk("R5 mask readback", d, 8'hFF);
    wr(1'b1, 8'h00); chk("R5 restore re-enables", 8'(cpu_int), 8'h01);
    ack(1'b1, v); chk("R5 vector after restore", v, 8'h22);
    wr(1'b0, 8'h62); line(2, 1'b0);
  endtask

  task automatic t_spurious();
    logic [7:0] d, v;
    line(6, 1'b1); chk("R4 line 6 pending", 8'(cpu_int), 8'h01);
    line(6, 1'b0); chk("R4 fall withdraws request", 8'(cpu_int), 8'h00);
    ack(1'b1, v); chk("R9 spurious vector", v, 8'h27);
    rd(1'b0, d); chk("R9 no in-service bit", d, 8'h00);
  endtask

  task automatic t_auto_retire();
    logic [7:0] d, v;
    line(4, 1'b1); ack(1'b1, v); chk("R3 vector line 4", v, 8'h24);
    line(5, 1'b1);
    wr(1'b1, 8'h10);
    wr(1'b0, 8'h11);
    rd(1'b1, d); chk("R2 restart clears mask", d, 8'h00);
    rd(1'b0, d); chk("R2 restart selects request readback", d, 8'h20);
    wr(1'b1, 8'h4D); wr(1'b1, 8'h04); wr(1'b1, 8'h03);
    chk("R2 in-service cleared by restart", 8'(cpu_int), 8'h01);
    ack(1'b0, v); chk("R3 low base bits ignored", v, 8'h4D);
    wr(1'b0, 8'h0B); rd(1'b0, d); chk("R12 held while vector waits", d, 8'h20);
    take();
    rd(1'b0, d); chk("R12 cleared at transfer", d, 8'h00);
    line(4, 1'b0); line(5, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all R): got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_init_short();
    t_init_full();
    t_basic();
    t_prio();
    t_backpressure();
    t_mask();
    t_spurious();
    t_auto_retire();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule